// File: doc/BRIEF.md
# Receive-FIFO Request-to-Send Flow Control

This block produces the request-to-send pin of a serial receiver. It holds a small control word and decides the pin level each clock. In software mode the pin copies a bit that firmware writes. In FIFO mode the receiver's fill count controls the pin, and a trigger-select bit picks one of two thresholds. The first is a programmable level marker. The second is the point where the FIFO has exactly one free slot left.

In FIFO mode the request asserts only when the fill count lands exactly on the threshold. It then stays asserted while the count remains at or above that threshold, so a full FIFO does not make the pin toggle. The FIFO storage, its count logic and the transmit side sit outside the block. The surrounding logic supplies the current fill count and the FIFO depth, and writes the control word through a simple write strobe.

Top module: `rts_flow_ctrl`

## Requirements
- R1: While reset is active and after it is released, every control field is 0, the readback word is 0, and the pin is at its inactive level, which is high by default.
- R2: When bit 7 of the control word is 0 (software mode), the request is asserted exactly when bit 6 (the software request bit) is 1, and the fill count has no effect on the pin.
- R3: The readback word returns the level marker in bits [5:0], the software request in bit 6, the mode in bit 7 and the trigger select in bit 8. Bit 9 and every bit above it always read 0, whatever value was written.
- R4: With bit 7 = 1 and bit 8 = 0, the request asserts when the fill count equals the level marker and the marker does not exceed the FIFO depth.
- R5: Once asserted in FIFO mode, the request stays asserted while the fill count is at or above the active threshold. It releases in the cycle after the count drops below that threshold.
- R6: In FIFO mode the request is not asserted when the fill count moves past the threshold without ever equalling it.
- R7: With bit 7 = 1 and bit 8 = 1, the threshold is the FIFO depth minus one. The request asserts when one slot is free and stays asserted when the FIFO is full.
- R8: A level marker larger than the FIFO depth never asserts the request.
- R9: With the default active-low polarity, an asserted request drives the pin to 0 and an idle request drives it to 1.
- R10: The pin is registered. It reflects the fill count, the depth and the control word as they were during the previous clock cycle, so a control write shows on the pin two edges after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | REG_W (16) | Control word write value |
| cfg_rd_data | output | REG_W (16) | Control word readback |
| rx_fill | input | CNT_W (7) | Number of occupied receive FIFO slots |
| rx_depth | input | CNT_W (7) | Number of slots in the receive FIFO |
| rts_pin | output | 1 | Request-to-send pin level |

## Verification
The checker watches every cycle for the following:
- The reserved readback bits stay 0.
- In software mode the pin tracks the software bit one cycle later.
- An exact marker match or a one-free-slot count always asserts the request on the next cycle.
- A count below the active threshold, or a marker above the depth, always leaves the request idle.

Only the bench scenarios can show the effects that depend on history. These are the hold at a full FIFO, the count that steps over the threshold without asserting, and the two-edge latency of a control write. The bench shows them by driving ordered fill sequences and comparing the pin against a cycle-accurate reference model.

// File: rtl/rts_fc_pkg.sv
package rts_fc_pkg;

   // Control word bit positions (mode, trigger and reserved are fixed)
   localparam int unsigned POS_SW   = 6;
   localparam int unsigned POS_MODE = 7;
   localparam int unsigned POS_TRIG = 8;
   localparam int unsigned POS_RSV  = 9;

   typedef struct packed {
      logic trig_sel;
      logic fifo_mode;
      logic sw_req;
   } rts_ctl_t;

   typedef enum logic [1:0] {
      SRC_SOFT     = 2'd0,
      SRC_MARKER   = 2'd1,
      SRC_ONE_FREE = 2'd2
   } rts_src_e;

endpackage

// File: rtl/rts_fc_ctrl_reg.sv
module rts_fc_ctrl_reg
   import rts_fc_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int MARK_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output rts_ctl_t          ctl,
   output logic [MARK_W-1:0] marker,
   output logic [REG_W-1:0]  rd_data
);

   generate
      if (MARK_W > int'(POS_SW)) begin : g_bad_mark
         $error("rts_fc_ctrl_reg: marker field overlaps control bits");
      end
      if (REG_W <= int'(POS_RSV)) begin : g_bad_regw
         $error("rts_fc_ctrl_reg: register too narrow for control bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '0;
         marker <= '0;
      end else if (wr_en) begin
         ctl.trig_sel  <= wr_data[POS_TRIG];
         ctl.fifo_mode <= wr_data[POS_MODE];
         ctl.sw_req    <= wr_data[POS_SW];
         marker        <= wr_data[MARK_W-1:0];
      end
   end

   // Reserved and unused bits read as zero
   always_comb begin
      rd_data               = '0;
      rd_data[MARK_W-1:0]   = marker;
      rd_data[POS_SW]       = ctl.sw_req;
      rd_data[POS_MODE]     = ctl.fifo_mode;
      rd_data[POS_TRIG]     = ctl.trig_sel;
   end

endmodule

// File: rtl/rts_fc_thresh.sv
module rts_fc_thresh
   import rts_fc_pkg::*;
#(
   parameter int CNT_W  = 7,
   parameter int MARK_W = 6
) (
   input  rts_ctl_t          ctl,
   input  logic [MARK_W-1:0] marker,
   input  logic [CNT_W-1:0]  depth,
   output rts_src_e          src,
   output logic [CNT_W-1:0]  thr,
   output logic              thr_ok
);

   generate
      if (MARK_W > CNT_W) begin : g_bad_w
         $error("rts_fc_thresh: marker wider than fill count");
      end
   endgenerate

   logic [CNT_W-1:0] marker_ext;
   assign marker_ext = CNT_W'(marker);

   always_comb begin
      src    = SRC_SOFT;
      thr    = '0;
      thr_ok = 1'b0;
      if (ctl.fifo_mode) begin
         if (ctl.trig_sel) begin
            src    = SRC_ONE_FREE;
            thr    = depth - CNT_W'(1);
            thr_ok = (depth != '0);
         end else begin
            src    = SRC_MARKER;
            thr    = marker_ext;
            thr_ok = (marker_ext <= depth);
         end
      end
   end

endmodule

// File: rtl/rts_fc_track.sv
module rts_fc_track
   import rts_fc_pkg::*;
#(
   parameter int CNT_W      = 7,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rts_src_e         src,
   input  logic [CNT_W-1:0] thr,
   input  logic             thr_ok,
   input  logic [CNT_W-1:0] fill,
   input  logic             sw_req,
   output logic             rts_pin
);

   logic held_q;
   logic req_q;
   logic hit;
   logic keep;
   logic fifo_nxt;

   assign hit      = thr_ok && (fill == thr);
   assign keep     = held_q && thr_ok && (fill >= thr);
   assign fifo_nxt = hit || keep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         case (src)
            SRC_SOFT: begin
               held_q <= 1'b0;
               req_q  <= sw_req;
            end
            default: begin
               held_q <= fifo_nxt;
               req_q  <= fifo_nxt;
            end
         endcase
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_low
         assign rts_pin = ~req_q;
      end else begin : g_high
         assign rts_pin = req_q;
      end
   endgenerate

endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
   import rts_fc_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int MARK_W     = 6,
   parameter int REG_W      = 16,
   parameter bit ACTIVE_LOW = 1'b1,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [REG_W-1:0] cfg_wr_data,
   output logic [REG_W-1:0] cfg_rd_data,
   input  logic [CNT_W-1:0] rx_fill,
   input  logic [CNT_W-1:0] rx_depth,
   output logic             rts_pin
);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("rts_flow_ctrl: FIFO_DEPTH must be at least 2");
      end
      if (MARK_W > CNT_W) begin : g_bad_mark
         $error("rts_flow_ctrl: MARK_W exceeds fill count width");
      end
   endgenerate

   rts_ctl_t          ctl;
   logic [MARK_W-1:0] marker;
   rts_src_e          src;
   logic [CNT_W-1:0]  thr;
   logic              thr_ok;

   rts_fc_ctrl_reg #(.REG_W(REG_W), .MARK_W(MARK_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .ctl     (ctl),
      .marker  (marker),
      .rd_data (cfg_rd_data)
   );

   rts_fc_thresh #(.CNT_W(CNT_W), .MARK_W(MARK_W)) u_thr (
      .ctl    (ctl),
      .marker (marker),
      .depth  (rx_depth),
      .src    (src),
      .thr    (thr),
      .thr_ok (thr_ok)
   );

   rts_fc_track #(.CNT_W(CNT_W), .ACTIVE_LOW(ACTIVE_LOW)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src),
      .thr     (thr),
      .thr_ok  (thr_ok),
      .fill    (rx_fill),
      .sw_req  (ctl.sw_req),
      .rts_pin (rts_pin)
   );

endmodule

// File: rtl/rts_flow_ctrl_chk.sv
module rts_flow_ctrl_chk
   import rts_fc_pkg::*;
#(
   parameter int CNT_W      = 7,
   parameter int MARK_W     = 6,
   parameter int REG_W      = 16,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] cfg_rd_data,
   input logic [CNT_W-1:0] rx_fill,
   input logic [CNT_W-1:0] rx_depth,
   input logic             rts_pin
);

   logic             act;
   logic             mode;
   logic             trig;
   logic [CNT_W-1:0] mark;
   logic [CNT_W:0]   fill_p1;
   logic [CNT_W:0]   depth_x;

   assign act     = ACTIVE_LOW ? ~rts_pin : rts_pin;
   assign mode    = cfg_rd_data[POS_MODE];
   assign trig    = cfg_rd_data[POS_TRIG];
   assign mark    = CNT_W'(cfg_rd_data[MARK_W-1:0]);
   assign fill_p1 = {1'b0, rx_fill} + (CNT_W+1)'(1);
   assign depth_x = {1'b0, rx_depth};

   // R3: reserved bits never read back nonzero
   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_data[REG_W-1:POS_RSV] == '0);

   // R2: software mode follows the software bit one cycle later
   p_sw_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mode |=> (act == $past(cfg_rd_data[POS_SW])));

   // R4: exact marker match asserts
   p_marker_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && !trig && (mark <= rx_depth) && (rx_fill == mark)) |=> act);

   // R5: count below threshold releases
   p_below_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && ((!trig && (rx_fill < mark)) || (trig && (fill_p1 < depth_x))))
      |=> !act);

   // R7: one free slot asserts
   p_one_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && trig && (rx_depth != '0) && (fill_p1 == depth_x)) |=> act);

   // R8: marker beyond depth never asserts
   p_marker_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && !trig && (mark > rx_depth)) |=> !act);

endmodule

bind rts_flow_ctrl rts_flow_ctrl_chk #(
   .CNT_W(CNT_W), .MARK_W(MARK_W), .REG_W(REG_W), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_rd_data (cfg_rd_data),
   .rx_fill     (rx_fill),
   .rx_depth    (rx_depth),
   .rts_pin     (rts_pin)
);

// File: tb/tb_rts_flow_ctrl.sv
module tb_rts_flow_ctrl;

   localparam int CNT_W = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [15:0] cfg_wr_data = '0;
   logic [15:0] cfg_rd_data;
   logic [CNT_W-1:0] rx_fill = '0;
   logic [CNT_W-1:0] rx_depth = 7'd64;
   logic        rts_pin;

   int checks = 0;
   int fails  = 0;

   bit    exp_q[$];
   string tag_q[$];

   // reference model state
   int m_mark = 0;
   bit m_mode = 0, m_trig = 0, m_sw = 0, m_lat = 0;
   int cur_fill = 0, cur_depth = 64;

   always #5 clk = ~clk;

   rts_flow_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(cfg_rd_data), .rx_fill(rx_fill), .rx_depth(rx_depth), .rts_pin(rts_pin)
   );

   function automatic bit model_pin();
      int thr;
      bit ok, nf, req;
      if (m_trig) begin thr = cur_depth - 1; ok = (cur_depth > 0); end
      else        begin thr = m_mark;        ok = (m_mark <= cur_depth); end
      nf = (ok && cur_fill == thr) || (m_lat && ok && cur_fill >= thr);
      if (m_mode) begin m_lat = nf; req = nf; end
      else        begin m_lat = 0;  req = m_sw; end
      return !req; // R9: active-low pin
   endfunction

   task automatic cyc(input int f, input int d, input string tag);
      bit e;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      rx_fill = CNT_W'(f); rx_depth = CNT_W'(d);
      cur_fill = f; cur_depth = d;
      e = model_pin();
      @(posedge clk);
      exp_q.push_back(e); tag_q.push_back(tag);
   endtask

   task automatic wr(input logic [15:0] v, input string tag);
      bit e;
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_data = v;
      e = model_pin();
      m_mark = int'(v[5:0]); m_sw = v[6]; m_mode = v[7]; m_trig = v[8];
      @(posedge clk);
      exp_q.push_back(e); tag_q.push_back(tag);
      #1;
   endtask

   task automatic chk_rd(input logic [15:0] e, input string tag);
      checks++;
      if (cfg_rd_data !== e) begin
         fails++;
         $display("FAIL %s: readback actual %h expected %h", tag, cfg_rd_data, e);
      end
   endtask

   // monitor: scoreboard pops one expectation per cycle
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            bit e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (rts_pin !== e) begin
               fails++;
               $display("FAIL %s: rts_pin actual %b expected %b", t, rts_pin, e);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (rts_pin !== 1'b1) begin fails++; $display("FAIL R1: pin actual %b expected 1", rts_pin); end
      chk_rd(16'h0000, "R1 reset readback");
      rst_n = 1'b1;
      cyc(0, 64, "R1 idle after reset");

      // R2: software mode
      wr(16'h0040, "R10 old sw value still shown");
      chk_rd(16'h0040, "R3 sw bit readback");
      cyc(0, 64, "R2 sw asserted R9");
      wr(16'h0000, "R2 sw still asserted");
      cyc(64, 64, "R2 fill ignored in sw mode");
      cyc(64, 64, "R2 fill ignored in sw mode");

      // R3: reserved bits
      wr(16'hFFFF, "R3 write all ones");
      chk_rd(16'h01FF, "R3 reserved read zero");
      cyc(64, 64, "R6 full without equality stays idle");

      // R4 / R5 / R6 marker mode
      wr(16'h008A, "R4 enter marker mode");
      chk_rd(16'h008A, "R3 marker readback");
      cyc(8, 64, "R4 below marker");
      cyc(9, 64, "R4 below marker");
      cyc(10, 64, "R4 marker match");
      cyc(11, 64, "R5 hold above");
      cyc(12, 64, "R5 hold above");
      cyc(9, 64, "R5 release below");
      cyc(11, 64, "R6 stepped over marker");
      cyc(10, 64, "R4 match again");
      cyc(0, 64, "R5 release at empty");

      // R7 one-free mode
      wr(16'h0180, "R7 enter one-free mode");
      cyc(62, 64, "R7 two free");
      cyc(63, 64, "R7 one free asserts");
      cyc(64, 64, "R7 hold when full");
      cyc(63, 64, "R7 hold at one free");
      cyc(62, 64, "R5 release below depth-1");
      cyc(14, 16, "R7 small depth");
      cyc(15, 16, "R7 small depth one free");
      cyc(16, 16, "R7 small depth full");

      // R8 marker beyond depth
      wr(16'h00A8, "R8 marker 40");
      cyc(32, 32, "R8 marker over depth");
      cyc(32, 32, "R8 marker over depth");
      cyc(31, 32, "R8 marker over depth");

      // R10: control write latency with fill already at marker
      cyc(5, 64, "R10 before write");
      wr(16'h0085, "R10 write cycle old control");
      cyc(5, 64, "R10 one cycle later");
      cyc(5, 64, "R10 asserted");
      wr(16'h0040, "R10 still fifo control");
      cyc(5, 64, "R2 back to sw");

      repeat (2) @(negedge clk);
      #1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule